// File: doc/BRIEF.md
# Multiplexed-Address Asynchronous DRAM Controller

This block turns single-beat requests from a synchronous client into the strobe sequences that an asynchronous DRAM with a shared row/column address bus expects. The client presents an 18-bit word address, a read/write flag and 8 bits of write data under a valid/ready handshake. The controller splits the address into a 9-bit row and a 9-bit column and presents them on the 9 address pins, one after the other. It lowers the row strobe, then the column strobe, and drives the write-enable and output-enable lines. Read results come back on a one-clock valid pulse.

Every analog minimum of the device is held as a cycle count parameter: row-strobe cycle time, row-to-data access, column-to-data access and the column-to-column page cycle. After an access the row stays open. A later request to the same row issues only a new column strobe, and a request to another row closes the page first. A free-running interval timer schedules refresh. Each refresh is a row-strobe-only dummy activation, and the refresh row address advances through every row in turn. The device data pins are modelled as separate input, output and drive-enable signals.

Top module: `dram_seq_ctrl`

## Requirements
- R1: The row address is `req_addr[17:9]`, presented on `dram_addr` in the cycle where `dram_ras_n` falls. The column address is `req_addr[8:0]`, presented in the cycle where `dram_cas_n` falls.
- R2: While `dram_cas_n` is low for a write, `dram_we_n`=0, `dram_oe_n`=1, `dram_dq_oe`=1 and `dram_dq_out` holds the write data. For a read, `dram_we_n`=1, `dram_oe_n`=0 and `dram_dq_oe`=0.
- R3: `dram_we_n` and `dram_oe_n` are never both low.
- R4: Two successive falling edges of `dram_ras_n` are at least TRC clock cycles apart (default 22).
- R5: Read data is captured no earlier than the edge ending the TRAC-th cycle after the row strobe fell (default 12) and the TCAC-th cycle after the column strobe fell (default 3). It is returned in request order on `rd_data`, with `rd_valid` high for one clock.
- R6: Two successive falling edges of `dram_cas_n` are at least TPC clock cycles apart (default 7), and the column strobe only falls while the row strobe is low.
- R7: A request to the row that is still open, with no refresh since the previous access, is served by a column strobe alone, with no new row strobe.
- R8: A request to a different row, or any request after a refresh, closes the open row and opens the requested one with a new row strobe.
- R9: A refresh falls due every REF_INTERVAL cycles. It is a row-strobe-only cycle: `dram_ras_n` stays low for TRAC cycles and no column strobe occurs. Refresh rows run 0, 1, ... 511 and then wrap to 0.
- R10: A due refresh goes ahead of any waiting or new request. While it is due, `req_ready` stays low and no new column access begins.
- R11: `req_ready` is low while a column access, row opening, precharge or refresh is in progress. A request is taken only on a cycle where `req_valid` and `req_ready` are both high.
- R12: During and straight after reset, all four strobes are high, `dram_dq_oe`=0, `rd_valid`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address, row in the upper 9 bits |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-clock pulse with read data |
| rd_data | output | 8 | Read data |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 8 | Data towards the device |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 8 | Data from the device |

## Verification
The bench's memory model returns the inverse of the stored byte whenever the row or column access time has not yet elapsed. A controller that samples a cycle early therefore hands back corrupted data instead of slightly late data. Same-row bursts are interleaved with row changes and with refreshes at awkward moments. A design that keeps the page open across a refresh, or that re-opens the row on a hit, shows the wrong row-strobe activity at the column edge. A long idle stretch runs the refresh row past 511 to catch a counter that stops at or skips the wrap. Back-to-back page hits sit right at the column cycle limit, and successive row openings sit right at the row cycle limit, so a counter that is one cycle short is caught at once.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ROW  = 3'd1,
        ST_COL  = 3'd2,
        ST_DATA = 3'd3,
        ST_PAGE = 3'd4,
        ST_PRE  = 3'd5
    } seq_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_elapsed_ctr.sv
module dram_elapsed_ctr #(
    parameter int LIMIT = 21,
    parameter int CW    = $clog2(LIMIT + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    output logic [CW-1:0] count_o
);
    localparam logic [CW-1:0] SAT = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart_i) begin
            cnt_d = '0;
        end else if (cnt_q != SAT) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= SAT;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int INTERVAL = 780,
    parameter int ROW_W    = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             pend_o,
    output logic [ROW_W-1:0] row_o
);
    localparam int TW = $clog2(INTERVAL + 1);
    localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

    typedef struct packed {
        logic [TW-1:0]    tmr;
        logic             pend;
        logic [ROW_W-1:0] row;
    } sched_t;

    sched_t d, q;

    always_comb begin
        d = q;
        if (q.tmr == LAST) begin
            d.tmr  = '0;
            d.pend = 1'b1;
        end else begin
            d.tmr = q.tmr + 1'b1;
            if (start_i) begin
                d.pend = 1'b0;
            end
        end
        if (start_i) begin
            d.row = q.row + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pend_o = q.pend;
    assign row_o  = q.row;

    // R10
    refresh_start_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> pend_o)
        else $error("refresh started without a pending request");

    // R9
    refresh_pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !start_i) |=> pend_o)
        else $error("pending refresh dropped before it was issued");

    // R9
    refresh_row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (row_o == $past(row_o) + 1'b1))
        else $error("refresh row did not advance by one");

endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
    import dram_seq_pkg::*;
#(
    parameter int ROW_W        = 9,
    parameter int COL_W        = 9,
    parameter int DATA_W       = 8,
    parameter int TRC          = 22,
    parameter int TRAC         = 12,
    parameter int TCAC         = 3,
    parameter int TPC          = 7,
    parameter int REF_INTERVAL = 780
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ROW_W+COL_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     rd_valid,
    output logic [DATA_W-1:0]        rd_data,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
    output logic                     dram_ras_n,
    output logic                     dram_cas_n,
    output logic                     dram_we_n,
    output logic                     dram_oe_n,
    output logic [DATA_W-1:0]        dram_dq_out,
    output logic                     dram_dq_oe,
    input  logic [DATA_W-1:0]        dram_dq_in
);
    localparam int ADDR_W  = ROW_W + COL_W;
    localparam int PIN_W   = imax(ROW_W, COL_W);
    localparam int RAS_LIM = imax(TRC, TRAC) - 1;
    localparam int CAS_LIM = imax(TPC, TCAC) - 1;
    localparam int RAS_CW  = $clog2(RAS_LIM + 2);
    localparam int CAS_CW  = $clog2(CAS_LIM + 2);
    localparam logic [RAS_CW-1:0] RC_MIN = RAS_CW'(TRC - 1);
    localparam logic [RAS_CW-1:0] RA_MIN = RAS_CW'(TRAC - 1);
    localparam logic [CAS_CW-1:0] CA_MIN = CAS_CW'(TCAC - 1);
    localparam logic [CAS_CW-1:0] PC_MIN = CAS_CW'(TPC - 1);

    typedef struct packed {
        seq_state_e        state;
        logic              refresh;
        logic              hold;
        logic [ROW_W-1:0]  open_row;
        logic [ROW_W-1:0]  req_row;
        logic [COL_W-1:0]  req_col;
        logic              req_wr;
        logic [DATA_W-1:0] req_wdata;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic [PIN_W-1:0]  addr;
        logic [DATA_W-1:0] dq_out;
        logic [DATA_W-1:0] rd_data;
        logic              rd_valid;
    } ctl_t;

    ctl_t d, q;

    logic [RAS_CW-1:0] ras_age;
    logic [CAS_CW-1:0] cas_age;
    logic              ref_pend;
    logic [ROW_W-1:0]  ref_row;
    logic              ref_start;
    logic              ras_fall_nxt;
    logic              cas_fall_nxt;
    logic              rc_ok, ra_ok, ca_ok, pc_ok;
    logic              accept;
    logic [ROW_W-1:0]  in_row;
    logic [COL_W-1:0]  in_col;

    assign in_row = req_addr[ADDR_W-1:COL_W];
    assign in_col = req_addr[COL_W-1:0];

    assign rc_ok = (ras_age >= RC_MIN);
    assign ra_ok = (ras_age >= RA_MIN);
    assign ca_ok = (cas_age >= CA_MIN);
    assign pc_ok = (cas_age >= PC_MIN);

    // A request is taken only from an idle or open-page state that can start it now.
    assign req_ready = !q.hold && !ref_pend &&
                       (((q.state == ST_IDLE) && rc_ok) ||
                        ((q.state == ST_PAGE) && pc_ok));
    assign accept = req_valid && req_ready;

    dram_elapsed_ctr #(.LIMIT(RAS_LIM), .CW(RAS_CW)) ras_age_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (ras_fall_nxt),
        .count_o   (ras_age)
    );

    dram_elapsed_ctr #(.LIMIT(CAS_LIM), .CW(CAS_CW)) cas_age_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (cas_fall_nxt),
        .count_o   (cas_age)
    );

    dram_refresh_sched #(.INTERVAL(REF_INTERVAL), .ROW_W(ROW_W)) refresh_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (ref_start),
        .pend_o  (ref_pend),
        .row_o   (ref_row)
    );

    always_comb begin
        d          = q;
        d.rd_valid = 1'b0;
        ref_start  = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (ref_pend && rc_ok) begin
                    d.state   = ST_ROW;
                    d.refresh = 1'b1;
                    d.ras_n   = 1'b0;
                    d.addr    = PIN_W'(ref_row);
                    ref_start = 1'b1;
                end else if (q.hold && rc_ok) begin
                    d.state = ST_ROW;
                    d.hold  = 1'b0;
                    d.ras_n = 1'b0;
                    d.addr  = PIN_W'(q.req_row);
                end else if (accept) begin
                    d.state     = ST_ROW;
                    d.ras_n     = 1'b0;
                    d.addr      = PIN_W'(in_row);
                    d.req_row   = in_row;
                    d.req_col   = in_col;
                    d.req_wr    = req_write;
                    d.req_wdata = req_wdata;
                end
            end
            ST_ROW: begin
                if (q.refresh) begin
                    if (ra_ok) begin
                        d.state   = ST_PRE;
                        d.ras_n   = 1'b1;
                        d.refresh = 1'b0;
                    end
                end else begin
                    d.state    = ST_COL;
                    d.open_row = q.req_row;
                    d.cas_n    = 1'b0;
                    d.addr     = PIN_W'(q.req_col);
                    d.we_n     = !q.req_wr;
                    d.oe_n     = q.req_wr;
                    d.dq_oe    = q.req_wr;
                    d.dq_out   = q.req_wdata;
                end
            end
            ST_COL: begin
                if (ra_ok && ca_ok) begin
                    d.state = ST_DATA;
                    d.cas_n = 1'b1;
                    d.we_n  = 1'b1;
                    d.oe_n  = 1'b1;
                    d.dq_oe = 1'b0;
                    if (!q.req_wr) begin
                        d.rd_data  = dram_dq_in;
                        d.rd_valid = 1'b1;
                    end
                end
            end
            ST_DATA: begin
                d.state = ST_PAGE;
            end
            ST_PAGE: begin
                if (ref_pend) begin
                    d.state = ST_PRE;
                    d.ras_n = 1'b1;
                end else if (accept) begin
                    d.req_row   = in_row;
                    d.req_col   = in_col;
                    d.req_wr    = req_write;
                    d.req_wdata = req_wdata;
                    if (in_row == q.open_row) begin
                        d.state  = ST_COL;
                        d.cas_n  = 1'b0;
                        d.addr   = PIN_W'(in_col);
                        d.we_n   = !req_write;
                        d.oe_n   = req_write;
                        d.dq_oe  = req_write;
                        d.dq_out = req_wdata;
                    end else begin
                        d.state = ST_PRE;
                        d.hold  = 1'b1;
                        d.ras_n = 1'b1;
                    end
                end
            end
            ST_PRE: begin
                d.state = ST_IDLE;
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    assign ras_fall_nxt = q.ras_n && !d.ras_n;
    assign cas_fall_nxt = q.cas_n && !d.cas_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.ras_n <= 1'b1;
            q.cas_n <= 1'b1;
            q.we_n  <= 1'b1;
            q.oe_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rd_valid    = q.rd_valid;
    assign rd_data     = q.rd_data;
    assign dram_addr   = q.addr;
    assign dram_ras_n  = q.ras_n;
    assign dram_cas_n  = q.cas_n;
    assign dram_we_n   = q.we_n;
    assign dram_oe_n   = q.oe_n;
    assign dram_dq_out = q.dq_out;
    assign dram_dq_oe  = q.dq_oe;

    // Strobe-edge spacing watchers, built only from the pin-level outputs.
    logic        ras_prev_q, cas_prev_q;
    logic [15:0] ras_gap_q, cas_gap_q;
    logic        ras_fall_c, cas_fall_c;

    assign ras_fall_c = ras_prev_q && !dram_ras_n;
    assign cas_fall_c = cas_prev_q && !dram_cas_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_prev_q <= 1'b1;
            cas_prev_q <= 1'b1;
            ras_gap_q  <= '1;
            cas_gap_q  <= '1;
        end else begin
            ras_prev_q <= dram_ras_n;
            cas_prev_q <= dram_cas_n;
            ras_gap_q  <= ras_fall_c ? 16'd1 : ((ras_gap_q == '1) ? ras_gap_q : ras_gap_q + 16'd1);
            cas_gap_q  <= cas_fall_c ? 16'd1 : ((cas_gap_q == '1) ? cas_gap_q : cas_gap_q + 16'd1);
        end
    end

    // R3
    we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dram_we_n && !dram_oe_n))
        else $error("write enable and output enable both active");

    // R4
    trc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ras_fall_c |-> (ras_gap_q >= 16'(TRC)))
        else $error("row strobes closer than the row cycle time");

    // R6
    tpc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cas_fall_c |-> (cas_gap_q >= 16'(TPC)))
        else $error("column strobes closer than the page cycle time");

    // R6
    cas_in_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n)
        else $error("column strobe active without an open row");

    // R2
    write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> (dram_dq_oe && !dram_cas_n))
        else $error("write enable without driven data under a column strobe");

    // R5
    rd_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(!dram_cas_n) && $past(!dram_oe_n)))
        else $error("read data returned without a read column cycle");

    // R11
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> dram_cas_n)
        else $error("ready raised during a column access");

endmodule

// File: tb/dram_seq_ctrl_tb_top.sv
module dram_seq_ctrl_tb_top;
    localparam int ROW_W   = 9;
    localparam int COL_W   = 9;
    localparam int DW      = 8;
    localparam int TRC     = 22;
    localparam int TRAC    = 12;
    localparam int TCAC    = 3;
    localparam int TPC     = 7;
    localparam int REF_INT = 100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [17:0]   req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic [8:0]    dram_addr;
    logic          dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
    logic [DW-1:0] dram_dq_out;
    logic          dram_dq_oe;
    logic [DW-1:0] dram_dq_in = '0;

    always #10 clk = ~clk;

    dram_seq_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW),
        .TRC(TRC), .TRAC(TRAC), .TCAC(TCAC), .TPC(TPC),
        .REF_INTERVAL(REF_INT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    typedef struct {
        int row;
        int col;
        bit wr;
        int data;
    } req_t;

    req_t req_q[$];
    int   rd_q[$];
    int   shadow[int];
    int   dmem[int];

    function automatic int init_val(input int a);
        return (a ^ (a >> 8) ^ (a >> 16)) & 255;
    endfunction

    function automatic int shadow_rd(input int a);
        return shadow.exists(a) ? shadow[a] : init_val(a);
    endfunction

    function automatic int dmem_rd(input int a);
        return dmem.exists(a) ? dmem[a] : init_val(a);
    endfunction

    task automatic issue(input int row, input int col, input bit wr, input int data);
        int a;
        a = row * 512 + col;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a[17:0];
        req_write = wr;
        req_wdata = data[7:0];
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        req_q.push_back('{row, col, wr, data & 255});
        if (wr) shadow[a] = data & 255;
        else    rd_q.push_back(shadow_rd(a));
    endtask

    // Behavioural device model and pin-level checks, evaluated once per clock.
    int cyc = 0;
    bit p_ras = 1'b1, p_cas = 1'b1;
    int last_rf = -100000, last_cf = -100000;
    int lat_row = 0, lat_col = 0;
    int cas_in = 0;
    bit ras_since = 1'b0, ref_since = 1'b0;
    int prev_row = -1;
    int exp_ref = 0, nref = 0;
    bit wrapped = 1'b0;
    int dues = 0, last_due = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            int  v;
            bit  overdue;
            cyc++;
            if (cyc % REF_INT == 0) begin
                dues++;
                last_due = cyc;
            end
            overdue = (dues > nref) && (cyc - last_due > 4);

            check(!(!dram_we_n && !dram_oe_n), "R3", "we_n/oe_n both low",
                  {dram_we_n, dram_oe_n}, 3);
            if (!dram_cas_n)
                check(!req_ready, "R11", "ready during column access", req_ready, 0);
            if (overdue)
                check(!req_ready, "R10", "ready while refresh due", req_ready, 0);

            if (p_ras && !dram_ras_n) begin
                check(cyc - last_rf >= TRC, "R4", "row strobe spacing", cyc - last_rf, TRC);
                last_rf   = cyc;
                lat_row   = int'(dram_addr);
                cas_in    = 0;
                ras_since = 1'b1;
            end

            if (p_cas && !dram_cas_n) begin
                check(!dram_ras_n, "R6", "column strobe without row", dram_ras_n, 0);
                check(cyc - last_cf >= TPC, "R6", "column strobe spacing", cyc - last_cf, TPC);
                check(!overdue, "R10", "column access while refresh due", 1, 0);
                last_cf = cyc;
                lat_col = int'(dram_addr);
                cas_in++;
                if (req_q.size() == 0) begin
                    check(1'b0, "R11", "column access with no request", 1, 0);
                end else begin
                    req_t r;
                    bit   exp_hit;
                    r = req_q.pop_front();
                    check(lat_row == r.row, "R1", "row address", lat_row, r.row);
                    check(lat_col == r.col, "R1", "column address", lat_col, r.col);
                    if (r.wr) begin
                        check(!dram_we_n && dram_oe_n && dram_dq_oe, "R2", "write strobes",
                              {dram_we_n, dram_oe_n, dram_dq_oe}, 3'b011);
                        check(int'(dram_dq_out) == r.data, "R2", "write data",
                              dram_dq_out, r.data);
                    end else begin
                        check(dram_we_n && !dram_oe_n && !dram_dq_oe, "R2", "read strobes",
                              {dram_we_n, dram_oe_n, dram_dq_oe}, 3'b100);
                    end
                    exp_hit = (prev_row == r.row) && !ref_since;
                    if (exp_hit)
                        check(!ras_since, "R7", "page hit reopened row", ras_since, 0);
                    else
                        check(ras_since, "R8", "page miss without new row", ras_since, 1);
                    if (!dram_we_n) dmem[lat_row * 512 + lat_col] = int'(dram_dq_out);
                    prev_row  = r.row;
                    ras_since = 1'b0;
                    ref_since = 1'b0;
                end
            end

            if (!p_ras && dram_ras_n && cas_in == 0) begin
                check(lat_row == exp_ref, "R9", "refresh row order", lat_row, exp_ref);
                check(cyc - last_rf >= TRAC, "R9", "refresh row strobe width",
                      cyc - last_rf, TRAC);
                if (exp_ref == 0 && nref > 0) wrapped = 1'b1;
                exp_ref   = (exp_ref + 1) % 512;
                nref++;
                ref_since = 1'b1;
            end

            if (rd_valid) begin
                if (rd_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected read data", rd_data, 0);
                end else begin
                    int e;
                    e = rd_q.pop_front();
                    check(int'(rd_data) == e, "R5", "read data", rd_data, e);
                end
            end

            if (!dram_ras_n && !dram_cas_n && !dram_oe_n) begin
                v = dmem_rd(lat_row * 512 + lat_col);
                if ((cyc - last_rf + 1 >= TRAC) && (cyc - last_cf + 1 >= TCAC))
                    dram_dq_in = v[7:0];
                else
                    dram_dq_in = ~v[7:0];
            end else begin
                dram_dq_in = 8'h00;
            end

            p_ras = dram_ras_n;
            p_cas = dram_cas_n;
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual 0 expected 1");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R12: reset values
        check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R12", "strobes in reset",
              {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 4'hF);
        check(!dram_dq_oe, "R12", "drive enable in reset", dram_dq_oe, 0);
        check(!rd_valid, "R12", "rd_valid in reset", rd_valid, 0);
        @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(req_ready, "R12", "ready after reset", req_ready, 1);
        check(dram_ras_n && dram_cas_n, "R12", "strobes after reset",
              {dram_ras_n, dram_cas_n}, 3);

        // Corner addresses, write then read back (second access is a page hit)
        issue(0, 0, 1'b1, 8'h11);
        issue(0, 0, 1'b0, 0);
        issue(511, 511, 1'b1, 8'hEE);
        issue(511, 511, 1'b0, 0);
        issue(511, 0, 1'b0, 0);
        issue(0, 511, 1'b0, 0);

        // Same-row burst at the page cycle limit
        for (int c = 0; c < 6; c++) issue(37, c, 1'b1, 8'hA0 + c);
        for (int c = 0; c < 6; c++) issue(37, c, 1'b0, 0);

        // Alternating rows: every access is a miss
        for (int k = 0; k < 8; k++) issue((k % 2 == 0) ? 3 : 400, k, k % 3 == 0, 8'h50 + k);
        for (int k = 0; k < 8; k++) issue((k % 2 == 0) ? 3 : 400, k, 1'b0, 0);

        // Unwritten locations return the device contents
        issue(200, 100, 1'b0, 0);
        issue(201, 77, 1'b0, 0);

        // Long idle stretch: refresh rows run past the wrap
        repeat (52000) @(negedge clk);

        // Mixed traffic over a few rows with gaps
        for (int i = 0; i < 300; i++) begin
            int rsel;
            rsel = $urandom % 4;
            issue((rsel == 3) ? 511 : rsel, $urandom % 512, 1'($urandom % 2), $urandom % 256);
            if ($urandom % 5 == 0) repeat ($urandom % 30) @(negedge clk);
        end

        for (int k = 0; k < 500 && (rd_q.size() != 0 || req_q.size() != 0); k++)
            @(negedge clk);
        repeat (30) @(negedge clk);

        check(req_q.size() == 0, "R11", "requests left unserved", req_q.size(), 0);
        check(rd_q.size() == 0, "R5", "reads without data", rd_q.size(), 0);
        check(wrapped, "R9", "refresh row wrapped to 0", wrapped, 1);
        check(nref == dues || nref + 1 == dues, "R9", "refresh count", nref, dues);
        finish_run();
    end

endmodule